// File: doc/BRIEF.md
# SHA-1 Hash Engine with Register-Mapped Host Port

This block computes SHA-1 message digests behind a 32-bit memory-like slave port. The host writes one 512-bit message block as sixteen 32-bit words into holding registers and issues a start command through a control register. It then polls a status register until the engine is idle again and reads the 160-bit result as five 32-bit words. Message padding is the host's job. Each block that the host loads must already be padded.

The holding registers are separate from the engine's working state. The engine copies the block into its own expansion window when a command is accepted. The host can therefore write the following block while the current one is still being hashed. The result registers are refreshed only at the end of a block, so the previous digest stays readable for the whole run.

A command either starts a new message from the standard initial chaining value or continues from the chaining value of the previous block. One block takes one setup cycle, eighty round cycles and one final cycle.

Top module: `sha1_bus_wrapper`

## Requirements
- R1: After reset, the status register at address 0x09 reads 1: bit 0 (idle) is 1 and bit 1 (result valid) is 0. The result words at 0x20 to 0x24 read zero.
- R2: A write to address 0x10+i (i = 0..15) stores block word i, and a read of that address returns it. Word 0 is the most significant 32 bits of the 512-bit block.
- R3: A write to address 0x08 while idle accepts a command. Bit 0 set starts a new message from the standard initial chaining value. Bit 1 set alone continues from the chaining value left by the previous block. When both bits are set, bit 0 wins.
- R4: Once a command is accepted, the idle bit reads 0 for exactly 81 cycles and then reads 1 again.
- R5: The result words at 0x20+k (k = 0..4) hold the SHA-1 compression of the block. Word 0 is the most significant 32 bits of the digest.
- R6: Block words written while a block is being hashed do not change that block's result.
- R7: The valid bit clears when a command is accepted and sets when the block completes. The result registers keep their previous value until that completion.
- R8: A control write while the engine is busy is ignored.
- R9: A read returns zero when its address is unmapped or is the control register, and whenever chip-select is low.
- R10: Writes to the status and result addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip-select for the access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| readData | output | 32 | Read data, combinational from addr |

## Verification
The hardest case to reach is overlap: the host rewrites the holding registers and pokes the control register while eighty rounds are still running. The bench gets there by issuing the first block of a two-block message and then, inside the 81-cycle busy window, loading the entire second block. Inside the same window it reads the old result and the cleared valid bit, and it sends a command that must be ignored. The intermediate digest after the first block is compared against the bench's own compression function. A mixed-up copy or a restarted run would show up in that digest.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WORD_W       = 32;
  localparam int BLOCK_WORDS  = 16;
  localparam int DIGEST_WORDS = 5;
  localparam int ROUNDS       = 80;
  localparam int ADDR_W       = 8;
  localparam int BLOCK_BITS   = WORD_W * BLOCK_WORDS;
  localparam int DIGEST_BITS  = WORD_W * DIGEST_WORDS;
  localparam int ROUND_CNT_W  = $clog2(ROUNDS);
  localparam int BLOCK_IDX_W  = $clog2(BLOCK_WORDS);

  localparam logic [ADDR_W-1:0] ADDR_CTRL        = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_STATUS      = 8'h09;
  localparam logic [ADDR_W-1:0] ADDR_BLOCK_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_DIGEST_BASE = 8'h20;

  localparam logic [DIGEST_BITS-1:0] CHAIN_START =
    {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};

  typedef enum logic [1:0] {RD_NONE, RD_STATUS, RD_BLOCK, RD_DIGEST} rdSel_e;

  typedef struct packed {
    logic                   blockWe;
    logic [BLOCK_IDX_W-1:0] idx;
    logic [WORD_W-1:0]      wdata;
    logic                   startInit;
    logic                   startNext;
    rdSel_e                 rdSel;
  } busStrobe_t;
endpackage

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
  import sha1_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  logic                  shift,
  input  logic [BLOCK_BITS-1:0] block,
  output logic [WORD_W-1:0]     wCur
);
  logic [WORD_W-1:0] win [BLOCK_WORDS];
  logic [WORD_W-1:0] mixWord;

  assign mixWord = win[13] ^ win[8] ^ win[2] ^ win[0];
  assign wCur    = win[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BLOCK_WORDS; i++) win[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < BLOCK_WORDS; i++)
        win[i] <= block[BLOCK_BITS-1-WORD_W*i -: WORD_W];
    end else if (shift) begin
      for (int i = 0; i < BLOCK_WORDS-1; i++) win[i] <= win[i+1];
      win[BLOCK_WORDS-1] <= {mixWord[WORD_W-2:0], mixWord[WORD_W-1]};
    end
  end
endmodule

// File: rtl/sha1_round_engine.sv
module sha1_round_engine
  import sha1_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startInit,
  input  logic                   startNext,
  input  logic [BLOCK_BITS-1:0]  block,
  output logic                   ready,
  output logic                   done,
  output logic [DIGEST_BITS-1:0] sum
);
  typedef enum logic [1:0] {ST_IDLE, ST_ROUND, ST_FINAL} engState_e;

  engState_e              state;
  logic [ROUND_CNT_W-1:0] roundCnt;
  logic [WORD_W-1:0]      chain [DIGEST_WORDS];
  logic [WORD_W-1:0]      a, b, c, d, e;
  logic [WORD_W-1:0]      wCur, fVal, kVal, tmp;
  logic                   start;

  assign start = (startInit | startNext) && state == ST_IDLE;
  assign ready = state == ST_IDLE;
  assign done  = state == ST_FINAL;
  assign sum   = {chain[0] + a, chain[1] + b, chain[2] + c, chain[3] + d, chain[4] + e};

  sha1_msg_window i_window (
    .clk   (clk),
    .rstN  (rstN),
    .load  (start),
    .shift (state == ST_ROUND),
    .block (block),
    .wCur  (wCur)
  );

  always_comb begin
    if (roundCnt < ROUND_CNT_W'(20)) begin
      fVal = (b & c) | (~b & d);       kVal = 32'h5A827999;
    end else if (roundCnt < ROUND_CNT_W'(40)) begin
      fVal = b ^ c ^ d;                kVal = 32'h6ED9EBA1;
    end else if (roundCnt < ROUND_CNT_W'(60)) begin
      fVal = (b & c) | (b & d) | (c & d); kVal = 32'h8F1BBCDC;
    end else begin
      fVal = b ^ c ^ d;                kVal = 32'hCA62C1D6;
    end
    tmp = {a[WORD_W-6:0], a[WORD_W-1:WORD_W-5]} + fVal + e + kVal + wCur;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      roundCnt <= '0;
      {a, b, c, d, e} <= '0;
      for (int k = 0; k < DIGEST_WORDS; k++) chain[k] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          roundCnt <= '0;
          state    <= ST_ROUND;
          if (startInit) begin
            {a, b, c, d, e} <= CHAIN_START;
            for (int k = 0; k < DIGEST_WORDS; k++)
              chain[k] <= CHAIN_START[DIGEST_BITS-1-WORD_W*k -: WORD_W];
          end else begin
            {a, b, c, d, e} <= {chain[0], chain[1], chain[2], chain[3], chain[4]};
          end
        end
        ST_ROUND: begin
          a <= tmp;
          b <= a;
          c <= {b[1:0], b[WORD_W-1:2]};
          d <= c;
          e <= d;
          if (roundCnt == ROUND_CNT_W'(ROUNDS-1)) state <= ST_FINAL;
          else roundCnt <= roundCnt + 1'b1;
        end
        ST_FINAL: begin
          for (int k = 0; k < DIGEST_WORDS; k++)
            chain[k] <= sum[DIGEST_BITS-1-WORD_W*k -: WORD_W];
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sha1_bus_ctrl.sv
module sha1_bus_ctrl
  import sha1_pkg::*;
(
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              coreReady,
  output busStrobe_t        stb
);
  logic hitBlock, hitDigest, hitCtrl;

  assign hitBlock  = addr[ADDR_W-1:BLOCK_IDX_W] == ADDR_BLOCK_BASE[ADDR_W-1:BLOCK_IDX_W];
  assign hitDigest = addr >= ADDR_DIGEST_BASE &&
                     addr <  ADDR_DIGEST_BASE + ADDR_W'(DIGEST_WORDS);
  assign hitCtrl   = addr == ADDR_CTRL;

  always_comb begin
    stb           = '0;
    stb.wdata     = wdata;
    stb.idx       = addr[BLOCK_IDX_W-1:0];
    stb.rdSel     = RD_NONE;
    if (cs && we) begin
      stb.blockWe   = hitBlock;
      stb.startInit = hitCtrl && coreReady && wdata[0];
      stb.startNext = hitCtrl && coreReady && !wdata[0] && wdata[1];
    end else if (cs) begin
      if (addr == ADDR_STATUS) stb.rdSel = RD_STATUS;
      else if (hitBlock)       stb.rdSel = RD_BLOCK;
      else if (hitDigest)      stb.rdSel = RD_DIGEST;
    end
  end
endmodule

// File: rtl/sha1_bus_datapath.sv
module sha1_bus_datapath
  import sha1_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobe_t             stb,
  input  logic                   coreReady,
  input  logic                   coreDone,
  input  logic [DIGEST_BITS-1:0] coreSum,
  output logic [BLOCK_BITS-1:0]  blockFlat,
  output logic [DIGEST_BITS-1:0] digestHeld,
  output logic                   validFlag,
  output logic [WORD_W-1:0]      readData
);
  logic [WORD_W-1:0] blockRegs  [BLOCK_WORDS];
  logic [WORD_W-1:0] digestRegs [DIGEST_WORDS];

  for (genvar g = 0; g < BLOCK_WORDS; g++) begin : g_blockFlat
    assign blockFlat[BLOCK_BITS-1-WORD_W*g -: WORD_W] = blockRegs[g];
  end
  for (genvar g = 0; g < DIGEST_WORDS; g++) begin : g_digestFlat
    assign digestHeld[DIGEST_BITS-1-WORD_W*g -: WORD_W] = digestRegs[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BLOCK_WORDS; i++) blockRegs[i] <= '0;
    end else if (stb.blockWe) begin
      blockRegs[stb.idx] <= stb.wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DIGEST_WORDS; k++) digestRegs[k] <= '0;
      validFlag <= 1'b0;
    end else if (coreDone) begin
      for (int k = 0; k < DIGEST_WORDS; k++)
        digestRegs[k] <= coreSum[DIGEST_BITS-1-WORD_W*k -: WORD_W];
      validFlag <= 1'b1;
    end else if (stb.startInit || stb.startNext) begin
      validFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_STATUS: readData = {{(WORD_W-2){1'b0}}, validFlag, coreReady};
      RD_BLOCK:  readData = blockRegs[stb.idx];
      RD_DIGEST: readData = digestRegs[stb.idx[2:0]];
      default:   readData = '0;
    endcase
  end
endmodule

// File: rtl/sha1_bus_wrapper.sv
module sha1_bus_wrapper
  import sha1_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] readData
);
  busStrobe_t             stb;
  logic                   coreReady, coreDone, validFlag, cmdAccepted;
  logic [BLOCK_BITS-1:0]  blockFlat;
  logic [DIGEST_BITS-1:0] coreSum, digestHeld;

  assign cmdAccepted = stb.startInit | stb.startNext;

  sha1_bus_ctrl i_ctrl (
    .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .coreReady(coreReady), .stb(stb)
  );

  sha1_bus_datapath i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .coreReady(coreReady),
    .coreDone(coreDone), .coreSum(coreSum), .blockFlat(blockFlat),
    .digestHeld(digestHeld), .validFlag(validFlag), .readData(readData)
  );

  sha1_round_engine i_engine (
    .clk(clk), .rstN(rstN), .startInit(stb.startInit), .startNext(stb.startNext),
    .block(blockFlat), .ready(coreReady), .done(coreDone), .sum(coreSum)
  );
endmodule

// File: rtl/sha1_bus_checker.sv
module sha1_bus_checker
  import sha1_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   cs,
  input logic                   we,
  input logic [ADDR_W-1:0]      addr,
  input logic [WORD_W-1:0]      readData,
  input logic                   cmdAccepted,
  input logic                   coreReady,
  input logic                   coreDone,
  input logic                   validFlag,
  input logic [DIGEST_BITS-1:0] digestHeld
);
  logic [7:0] busyCnt;
  logic       readMapped;

  assign readMapped = addr == ADDR_STATUS ||
                      addr[ADDR_W-1:BLOCK_IDX_W] == ADDR_BLOCK_BASE[ADDR_W-1:BLOCK_IDX_W] ||
                      (addr >= ADDR_DIGEST_BASE && addr < ADDR_DIGEST_BASE + ADDR_W'(DIGEST_WORDS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyCnt <= '0;
    else if (coreReady) busyCnt <= '0;
    else                busyCnt <= busyCnt + 1'b1;
  end

  AST_CMD_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccepted |=> !coreReady); // R4
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreReady) |-> busyCnt == 8'(ROUNDS + 1)); // R4
  AST_NO_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !coreReady |-> !cmdAccepted); // R8
  AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccepted |=> !validFlag); // R7
  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !coreDone |=> $stable(digestHeld)); // R7
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |=> coreReady && validFlag); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!cs || we || !readMapped) |-> readData == '0); // R9
endmodule

bind sha1_bus_wrapper sha1_bus_checker i_checker (
  .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .readData(readData),
  .cmdAccepted(cmdAccepted), .coreReady(coreReady), .coreDone(coreDone),
  .validFlag(validFlag), .digestHeld(digestHeld)
);

// File: tb/test_sha1_bus_wrapper.sv
module test_sha1_bus_wrapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] readData;
  int          nCompared = 0, nMismatched = 0;

  localparam logic [159:0] IV = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
  localparam logic [159:0] ABC_DIGEST = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
  localparam logic [159:0] TWO_DIGEST = 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1;

  always #10 clk = ~clk;

  sha1_bus_wrapper i_sha1_bus_wrapper (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .wdata(wdata), .readData(readData)
  );

  function automatic logic [159:0] modelCompress(input logic [159:0] hIn, input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      t = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {t[30:0], t[31]};
    end
    {a, b, c, d, e} = hIn;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);         k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                  k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                  k = 32'hCA62C1D6; end
      t = {a[26:0], a[31:27]} + f + e + k + w[i];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
    end
    return {hIn[159:128] + a, hIn[127:96] + b, hIn[95:64] + c, hIn[63:32] + d, hIn[31:0] + e};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    #1 d = readData;
  endtask

  task automatic loadBlock(input logic [511:0] blk);
    for (int i = 0; i < 16; i++) busWrite(8'h10 + 8'(i), blk[511-32*i -: 32]);
  endtask

  task automatic waitReady(output int busy);
    busy = 0;
    cs = 1'b1; we = 1'b0; addr = 8'h09;
    #1;
    while (!readData[0] && busy < 300) begin
      busy++;
      @(negedge clk); #1;
    end
  endtask

  task automatic checkDigest(input string req, input logic [159:0] exp);
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      busRead(8'h20 + 8'(k), v);
      check(req, v, exp[159-32*k -: 32]);
    end
  endtask

  initial begin
    #(20 * 150000);
    nMismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    logic [511:0] abcBlk, blk1, blk2, blk;
    logic [159:0] h;
    logic [31:0]  v;
    int           busy;

    abcBlk = '0;
    abcBlk[511:480] = 32'h61626380;
    abcBlk[31:0]    = 32'h18;
    blk1 = '0;
    for (int i = 0; i < 14; i++)
      blk1[511-32*i -: 32] = {8'h61 + 8'(i), 8'h62 + 8'(i), 8'h63 + 8'(i), 8'h64 + 8'(i)};
    blk1[63:32] = 32'h80000000;
    blk2 = '0;
    blk2[31:0] = 32'd448;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    busRead(8'h09, v); check("R1 status", v, 32'h1);
    checkDigest("R1 digest zero", '0);

    // R9: unmapped and control reads
    busRead(8'h00, v); check("R9 addr 00", v, 0);
    busRead(8'h08, v); check("R9 ctrl", v, 0);
    busRead(8'h0A, v); check("R9 addr 0A", v, 0);
    busRead(8'h25, v); check("R9 addr 25", v, 0);
    busRead(8'hFF, v); check("R9 addr FF", v, 0);

    // R2: block words read back in order
    loadBlock(abcBlk);
    for (int i = 0; i < 16; i++) begin
      busRead(8'h10 + 8'(i), v); check("R2 readback", v, abcBlk[511-32*i -: 32]);
    end
    @(negedge clk); cs = 1'b0; addr = 8'h10; #1 check("R9 cs low", readData, 0);

    // R3/R4/R5: single block "abc"
    busWrite(8'h08, 32'h1);
    waitReady(busy); check("R4 busy span", busy, 81);
    busRead(8'h09, v); check("R7 valid set", v, 32'h3);
    checkDigest("R5 abc", ABC_DIGEST);
    checkDigest("R5 abc model", modelCompress(IV, abcBlk));

    // R10: read-only addresses
    busWrite(8'h20, 32'hDEADBEEF);
    busWrite(8'h09, 32'h0);
    busRead(8'h20, v); check("R10 digest write", v, ABC_DIGEST[159:128]);
    busRead(8'h09, v); check("R10 status write", v, 32'h3);

    // R6/R7/R8: two-block message, second block loaded during the first
    loadBlock(blk1);
    busWrite(8'h08, 32'h1);
    loadBlock(blk2);
    busRead(8'h09, v); check("R7 valid cleared busy", v, 32'h0);
    busRead(8'h20, v); check("R7 digest held", v, ABC_DIGEST[159:128]);
    busWrite(8'h08, 32'h1);
    busRead(8'h09, v); check("R8 still busy", v, 32'h0);
    waitReady(busy);
    checkDigest("R6 first block", modelCompress(IV, blk1));
    busWrite(8'h08, 32'h2);
    waitReady(busy); check("R4 busy span next", busy, 81);
    checkDigest("R3 next two-block", TWO_DIGEST);

    // R3: both bits set acts as a fresh start
    loadBlock(abcBlk);
    busWrite(8'h08, 32'h3);
    waitReady(busy);
    checkDigest("R3 init wins", ABC_DIGEST);

    // R3/R5: chained sweep over patterned blocks
    h = IV;
    for (int m = 0; m < 4; m++) begin
      for (int j = 0; j < 16; j++)
        blk[511-32*j -: 32] = (32'(m + 1) * 32'h9E3779B9) ^ (32'(j) * 32'h01000193) ^ 32'(j << m);
      loadBlock(blk);
      busWrite(8'h08, m == 0 ? 32'h1 : 32'h2);
      waitReady(busy);
      h = modelCompress(h, blk);
      checkDigest("R5 sweep", h);
    end

    @(negedge clk); cs = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule